// File: doc/BRIEF.md
# Receive Descriptor-Chain DMA Channel

This block is one receive-direction packet DMA channel. Software builds a chain of buffer descriptors in a small on-chip descriptor RAM through a word-wide bus port. It then starts the channel by writing the number of the first descriptor into the head register. The channel takes packets from a byte stream and writes each packet's bytes into the buffer that the current descriptor names, using a simple byte-write output. When a packet ends, the channel writes a status word back into that descriptor, which hands the descriptor back to software. It then follows the chain to the next descriptor.

A descriptor is four words at RAM word `4*n`: word 0 is the next-descriptor number (0 means none), word 1 is the buffer base address, word 2 is the buffer length (low 11 bits), and word 3 is the mode/status word. In the mode word, bit 31 is start of packet, bit 30 is end of packet, bit 29 is hardware ownership, bit 28 is end of queue, and bits 10:0 hold the length. Descriptor number 0 serves as the null pointer and cannot carry a buffer.

The bus port selects register space when address bit 6 is set, with the register index in bits 2:0. The registers are:
- 0: head descriptor
- 1: completion acknowledge
- 2: free-buffer count (a write adds to it)
- 3: control (bit 0 enables the channel)
- 4: soft reset (a write with bit 0 set triggers it)
- 5: overrun count

The channel needs one cycle to fetch a descriptor before it can accept the next packet.

Top module: `dma_rx_chan`

## Requirements
- R1: After reset the head, completion, free-count and overrun registers read 0, the channel is disabled, and mem_we stays low.
- R2: With the channel enabled, writing a nonzero descriptor number to the head register while idle starts a fetch. If that descriptor's mode bit 29 is set, byte k of the next packet is written to buffer base + k.
- R3: At the end of a packet the channel writes mode = bit31 | bit30 | length with bit 29 cleared, and bit 28 cleared when the next pointer is nonzero. The head register then reads the next descriptor, and the following packet lands in that descriptor's buffer.
- R4: When the finished descriptor's next pointer is 0, its mode word also gets bit 28 set, the channel goes idle, and the head register reads 0.
- R5: A fetched descriptor whose bit 29 is clear is left unchanged, the channel goes idle, and the head register reads 0.
- R6: After an end-of-queue stop, writing the head register again restarts the channel at the new descriptor.
- R7: Each write to register 2 adds its value to the free count. Each accepted packet lowers the count by one.
- R8: A packet whose first byte arrives while the free count is 0, or while the channel is not ready (idle, disabled or fetching), is dropped with no memory write, and the overrun count rises by one.
- R9: Bytes beyond the descriptor's buffer length are not written, and the stored length equals the number of bytes written.
- R10: A head-register write while the channel is busy with a descriptor has no effect.
- R11: Writing 1 to register 4 clears head, completion, free and overrun state, and register 4 reads 0.
- R12: Register 1 reads back the last descriptor number software acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Bus write strobe |
| cpu_addr | input | 7 | Bus word address; bit 6 selects registers |
| cpu_wdata | input | 32 | Bus write data |
| cpu_rdata | output | 32 | Bus read data (combinational) |
| in_valid | input | 1 | Receive byte valid |
| in_data | input | 8 | Receive byte |
| in_last | input | 1 | Last byte of packet |
| mem_we | output | 1 | Buffer byte write strobe |
| mem_addr | output | 32 | Buffer byte address |
| mem_wdata | output | 8 | Buffer byte data |

## Verification
The hardest state to reach is the end-of-queue stall followed by a software restart. To get there, the bench first runs a chain until a descriptor with a null next pointer is retired. It then links a new descriptor behind the stopped one and rewrites the head register. The bench also sends a packet that is longer than its buffer, which shows truncation and the length writeback together. It sends packets into an idle channel and into a channel with no free credits so that the overrun path is exercised. A scoreboard matches every buffer byte write against the queue of expected writes, so any stray write from a dropped packet is reported.

// File: rtl/dma_rx_pkg.sv
package dma_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_READY = 2'd2,
        ST_RECV  = 2'd3
    } dma_st_e;

    localparam int MODE_SOP   = 31;
    localparam int MODE_EOP   = 30;
    localparam int MODE_OWN   = 29;
    localparam int MODE_EOQ   = 28;

    localparam logic [2:0] RG_HEAD = 3'd0;
    localparam logic [2:0] RG_ACK  = 3'd1;
    localparam logic [2:0] RG_FREE = 3'd2;
    localparam logic [2:0] RG_CTRL = 3'd3;
    localparam logic [2:0] RG_SRST = 3'd4;
    localparam logic [2:0] RG_OVR  = 3'd5;
endpackage

// File: rtl/dma_desc_ram.sv
module dma_desc_ram #(
    parameter int NDESC = 16,
    parameter int LEN_W = 11,
    localparam int IDX_W = $clog2(NDESC),
    localparam int WA_W  = IDX_W + 2
) (
    input  logic             clk,
    input  logic             cpu_we,
    input  logic [WA_W-1:0]  cpu_word,
    input  logic [31:0]      cpu_wdata,
    output logic [31:0]      cpu_rdata,
    input  logic [IDX_W-1:0] eng_idx,
    output logic [IDX_W-1:0] eng_next,
    output logic [31:0]      eng_buf,
    output logic [LEN_W-1:0] eng_len,
    output logic             eng_own,
    input  logic             eng_we,
    input  logic [31:0]      eng_wdata
);
    logic [31:0] mem [NDESC*4];
    logic [WA_W-1:0] eng_mode_word;
    logic [31:0] w0, w2, w3;

    assign eng_mode_word = {eng_idx, 2'd3};
    assign cpu_rdata = mem[cpu_word];
    assign w0 = mem[{eng_idx, 2'd0}];
    assign eng_buf = mem[{eng_idx, 2'd1}];
    assign w2 = mem[{eng_idx, 2'd2}];
    assign w3 = mem[eng_mode_word];
    assign eng_next = w0[IDX_W-1:0];
    assign eng_len = w2[LEN_W-1:0];
    assign eng_own = w3[dma_rx_pkg::MODE_OWN];

    // The engine's status writeback wins over a software write to the same word.
    always_ff @(posedge clk) begin
        if (cpu_we && !(eng_we && cpu_word == eng_mode_word))
            mem[cpu_word] <= cpu_wdata;
        if (eng_we)
            mem[eng_mode_word] <= eng_wdata;
    end
endmodule

// File: rtl/dma_free_ctr.sv
module dma_free_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (add_en) cnt_d = cnt_d + add_val;
        if (dec)    cnt_d = cnt_d - W'(1);
        if (clr)    cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    a_r7_dec_only_when_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !add_en) |-> (cnt_q != '0));
endmodule

// File: rtl/dma_rx_chan.sv
module dma_rx_chan #(
    parameter int NDESC  = 16,
    parameter int LEN_W  = 11,
    parameter int FREE_W = 16,
    parameter int OVR_W  = 16,
    localparam int IDX_W = $clog2(NDESC),
    localparam int AW    = IDX_W + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [31:0]   cpu_wdata,
    output logic [31:0]   cpu_rdata,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [7:0]    mem_wdata
);
    import dma_rx_pkg::*;

    typedef struct packed {
        dma_st_e          st;
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] nxt;
        logic [31:0]      ack;
        logic             en;
        logic [31:0]      bufp;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] wcnt;
        logic             drop;
        logic [OVR_W-1:0] ovr;
    } chan_t;

    chan_t d, q;

    logic             reg_sel, reg_we, ram_we;
    logic [2:0]       reg_idx;
    logic [31:0]      ram_rdata;
    logic [IDX_W-1:0] f_next;
    logic [31:0]      f_buf;
    logic [LEN_W-1:0] f_len;
    logic             f_own;
    logic             eng_we;
    logic [31:0]      eng_wdata;
    logic [FREE_W-1:0] free_cnt;
    logic             fc_clr, fc_add, fc_dec;
    logic             first, take;
    logic [LEN_W-1:0] cnt_base, cnt_nxt;

    assign reg_sel = cpu_addr[AW-1];
    assign reg_idx = cpu_addr[2:0];
    assign reg_we  = cpu_we && reg_sel;
    assign ram_we  = cpu_we && !reg_sel;

    dma_desc_ram #(.NDESC(NDESC), .LEN_W(LEN_W)) u_ram (
        .clk(clk), .cpu_we(ram_we), .cpu_word(cpu_addr[AW-2:0]),
        .cpu_wdata(cpu_wdata), .cpu_rdata(ram_rdata),
        .eng_idx(q.head), .eng_next(f_next), .eng_buf(f_buf),
        .eng_len(f_len), .eng_own(f_own),
        .eng_we(eng_we), .eng_wdata(eng_wdata)
    );

    dma_free_ctr #(.W(FREE_W)) u_free (
        .clk(clk), .rst_n(rst_n), .clr(fc_clr), .add_en(fc_add),
        .add_val(cpu_wdata[FREE_W-1:0]), .dec(fc_dec), .cnt(free_cnt)
    );

    always_comb begin
        d         = q;
        eng_we    = 1'b0;
        eng_wdata = '0;
        mem_we    = 1'b0;
        mem_wdata = in_data;
        fc_dec    = 1'b0;
        fc_add    = 1'b0;
        fc_clr    = 1'b0;
        first     = in_valid && (q.st != ST_RECV) && !q.drop;
        take      = first && (q.st == ST_READY) && q.en && (free_cnt != '0);
        cnt_base  = take ? '0 : q.wcnt;
        mem_addr  = q.bufp + 32'(cnt_base);
        cnt_nxt   = cnt_base;

        case (q.st)
            ST_IDLE:  if (q.head != '0 && q.en) d.st = ST_FETCH;
            ST_FETCH: begin
                if (f_own && q.head != '0) begin
                    d.st   = ST_READY;
                    d.bufp = f_buf;
                    d.len  = f_len;
                    d.nxt  = f_next;
                end else begin
                    d.st   = ST_IDLE;
                    d.head = '0;
                end
            end
            default: ;
        endcase

        if (in_valid) begin
            if (take || q.st == ST_RECV) begin
                fc_dec = take;
                if (cnt_base < q.len) begin
                    mem_we  = 1'b1;
                    cnt_nxt = cnt_base + LEN_W'(1);
                end
                d.wcnt = cnt_nxt;
                if (in_last) begin
                    eng_we    = 1'b1;
                    eng_wdata = 32'(cnt_nxt);
                    eng_wdata[MODE_SOP] = 1'b1;
                    eng_wdata[MODE_EOP] = 1'b1;
                    eng_wdata[MODE_EOQ] = (q.nxt == '0);
                    d.head = q.nxt;
                    d.wcnt = '0;
                    d.st   = (q.nxt == '0) ? ST_IDLE : ST_FETCH;
                end else begin
                    d.st = ST_RECV;
                end
            end else begin
                if (first) d.ovr = q.ovr + OVR_W'(1);
                d.drop = !in_last;
            end
        end

        if (reg_we) begin
            case (reg_idx)
                RG_HEAD: if (q.st == ST_IDLE) d.head = cpu_wdata[IDX_W-1:0];
                RG_ACK:  d.ack = cpu_wdata;
                RG_FREE: fc_add = 1'b1;
                RG_CTRL: d.en = cpu_wdata[0];
                RG_SRST: if (cpu_wdata[0]) begin
                    d      = '0;
                    d.en   = q.en;
                    fc_clr = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (!reg_sel) cpu_rdata = ram_rdata;
        else begin
            case (reg_idx)
                RG_HEAD: cpu_rdata = 32'(q.head);
                RG_ACK:  cpu_rdata = q.ack;
                RG_FREE: cpu_rdata = 32'(free_cnt);
                RG_CTRL: cpu_rdata = 32'(q.en);
                RG_OVR:  cpu_rdata = 32'(q.ovr);
                default: cpu_rdata = '0;
            endcase
        end
    end

    logic srst_hit;
    assign srst_hit = reg_we && reg_idx == RG_SRST && cpu_wdata[0];

    a_r9_write_inside_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr - q.bufp) < 32'(q.len)));
    a_r3_writeback_releases: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> (!eng_wdata[MODE_OWN] && eng_wdata[MODE_SOP] && eng_wdata[MODE_EOP]));
    a_r4_eoq_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && eng_wdata[MODE_EOQ] && !srst_hit) |=> (q.st == ST_IDLE && q.head == '0));
    a_r8_overrun_step: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_hit |=> (q.ovr == $past(q.ovr) || q.ovr == $past(q.ovr) + OVR_W'(1)));
    a_r8_no_write_when_dropping: assert property (@(posedge clk) disable iff (!rst_n)
        q.drop |-> !mem_we);
    a_r10_head_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_READY || q.st == ST_RECV) && reg_we && reg_idx == RG_HEAD
         && !eng_we && !srst_hit) |=> $stable(q.head));
endmodule

// File: tb/dma_rx_chan_bench.sv
module dma_rx_chan_bench;
    localparam int REGB = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [6:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [39:0] exp_q[$];

    always #10 clk = ~clk;

    dma_rx_chan u_dma_rx_chan (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Monitor: every buffer write must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R8/R9: unexpected write addr %h data %h expected none", mem_addr, mem_wdata);
            end else begin
                logic [39:0] e;
                e = exp_q.pop_front();
                if ({mem_addr, mem_wdata} !== e) begin
                    n_fail++;
                    $display("FAIL R2: write got %h expected %h", {mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    task automatic wr(input int addr, input logic [31:0] data);
        @(posedge clk); #1;
        cpu_we = 1'b1; cpu_addr = 7'(addr); cpu_wdata = data;
        @(posedge clk); #1;
        cpu_we = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(posedge clk); #1;
        cpu_addr = 7'(addr);
        @(negedge clk);
        data = cpu_rdata;
    endtask

    task automatic desc(input int n, input int nxt, input int bufp, input int len, input logic [31:0] mode);
        wr(4*n, 32'(nxt));
        wr(4*n+1, 32'(bufp));
        wr(4*n+2, 32'(len));
        wr(4*n+3, mode);
    endtask

    // Driver: sends a packet and pushes the writes expected for it.
    task automatic send(input int nbytes, input int seed, input bit expect_wr, input int bufp, input int cap);
        for (int i = 0; i < nbytes; i++) begin
            if (expect_wr && i < cap)
                exp_q.push_back({32'(bufp + i), 8'(seed + i)});
            @(posedge clk); #1;
            in_valid = 1'b1; in_data = 8'(seed + i); in_last = (i == nbytes - 1);
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 mem_we", 32'(mem_we), 0);
        rd(REGB+0, v); check("R1 head", v, 0);
        rd(REGB+2, v); check("R1 free", v, 0);
        rd(REGB+5, v); check("R1 ovr", v, 0);
        rd(REGB+3, v); check("R1 enable", v, 0);

        wr(REGB+3, 1);
        send(3, 8'h10, 0, 0, 0);
        rd(REGB+5, v); check("R8 idle drop ovr", v, 1);

        desc(1, 2, 32'h1000, 64, 32'h2000_0000);
        desc(2, 0, 32'h2000, 4, 32'h2000_0000);
        wr(REGB+2, 2);
        rd(REGB+2, v); check("R7 free add", v, 2);

        wr(REGB+0, 1);
        repeat (3) @(posedge clk);
        send(5, 8'h40, 1, 32'h1000, 64);
        rd(4*1+3, v); check("R3 mode desc1", v, 32'hC000_0005);
        rd(REGB+2, v); check("R7 free dec", v, 1);
        rd(REGB+0, v); check("R3 head follows next", v, 2);

        wr(REGB+0, 5);
        rd(REGB+0, v); check("R10 head ignored busy", v, 2);

        send(6, 8'h80, 1, 32'h2000, 4);
        rd(4*2+3, v); check("R9/R4 mode desc2", v, 32'hD000_0004);
        rd(REGB+0, v); check("R4 head idle", v, 0);
        rd(REGB+2, v); check("R7 free zero", v, 0);

        send(2, 8'h90, 0, 0, 0);
        rd(REGB+5, v); check("R8 ovr after stall", v, 2);

        desc(3, 0, 32'h3000, 16, 32'h2000_0000);
        wr(4*2, 3);
        wr(REGB+2, 3);
        wr(REGB+0, 3);
        repeat (3) @(posedge clk);
        send(3, 8'hA0, 1, 32'h3000, 16);
        rd(4*3+3, v); check("R6 restart mode desc3", v, 32'hD000_0003);
        rd(REGB+2, v); check("R7 free after restart", v, 2);

        desc(4, 0, 32'h4000, 16, 32'h0);
        wr(REGB+0, 4);
        repeat (4) @(posedge clk);
        rd(REGB+0, v); check("R5 head cleared", v, 0);
        send(2, 8'hB0, 0, 0, 0);
        rd(4*4+3, v); check("R5 desc4 untouched", v, 0);
        rd(REGB+5, v); check("R8 ovr not owned", v, 3);

        wr(REGB+1, 3);
        rd(REGB+1, v); check("R12 ack readback", v, 3);

        wr(REGB+4, 1);
        rd(REGB+0, v); check("R11 head", v, 0);
        rd(REGB+1, v); check("R11 ack", v, 0);
        rd(REGB+2, v); check("R11 free", v, 0);
        rd(REGB+5, v); check("R11 ovr", v, 0);
        rd(REGB+4, v); check("R11 srst reads zero", v, 0);

        check("R2 all writes seen", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule